// File: doc/BRIEF.md
# Message-Signaled Interrupt File

This block is a single interrupt file for message-signaled interrupts. Every interrupt identity from 1 up to `NUM_IDS-1` has its own pending flag and enable flag. A device raises an interrupt by posting a 32-bit word to the memory-mapped port. The word is the identity, and the post must go to offset zero of the page. The block then looks for the lowest-numbered identity that is both pending and enabled, keeping only identities below a programmable threshold. When the delivery switch is on, it drives an external interrupt line.

Software uses a word-level read-modify-write register port to manage the file. That port covers the delivery switch, the threshold, the top-interrupt (claim) register, and the pending and enable words, each holding 32 identities. Writing the claim register clears the pending flag of the current winner, so the next one can come through.

Top module: `mif_msi_file`

## Requirements
- R1: Identity 0 does not exist. Bit 0 of pending word 0 (select 0x40) and of enable word 0 (select 0x80) always reads 0, and writes to that bit are dropped.
- R2: The top value is the lowest identity with both flags set. It is placed in bits 26:16 and again in bits 10:0, with every other bit zero. It is 0 when no identity qualifies. It is read at select 0x02.
- R3: If the threshold is nonzero and no greater than `NUM_IDS`, only identities strictly below it can win. A threshold of zero, or one above `NUM_IDS`, leaves every identity eligible.
- R4: Select 0x00 (delivery) keeps only bit 0 of a write. Select 0x01 (threshold) keeps only bits 10:0. Both follow the write mask bit by bit.
- R5: `irq_out` is 1 exactly when delivery is 1 and the top value is nonzero. It reflects each access from the cycle after that access is sampled.
- R6: A register access at select 0x02 with a nonzero write mask ignores the data and clears the pending flag of the identity that was on top. The access returns that old top value.
- R7: A 32-bit MMIO write to page offset 0 with data D sets pending flag D when 0 < D < `NUM_IDS`. Other data values change nothing. A write to offset 4 changes nothing. An MSI that lands in the same cycle as a register write takes precedence on the same flag.
- R8: An MMIO write that is misaligned (address bits 1:0 nonzero), outside the page (address bits 15:12 nonzero) or at any offset other than 0 has no effect. `mmio_rdata` is always zero.
- R9: A register access at select 0x40+w or 0x80+w (w < `NUM_IDS`/32) returns the old 32 flags of that word. It sets or clears only the flags whose write mask bit is 1, each to the matching data bit.
- R10: `reg_rvalid` rises the cycle after `reg_req`, with `reg_rdata` holding the old value. Any other select returns 0 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mmio_wr_en | input | 1 | MMIO write strobe |
| mmio_addr | input | ADDR_W | MMIO byte address |
| mmio_wdata | input | 32 | MMIO write data (identity) |
| mmio_rdata | output | 32 | MMIO read data, always zero |
| reg_req | input | 1 | Register access request |
| reg_sel | input | 8 | Register select |
| reg_wdata | input | 32 | New value for masked bits |
| reg_wmask | input | 32 | Write mask; zero for a pure read |
| reg_rdata | output | 32 | Old register value |
| reg_rvalid | output | 1 | `reg_rdata` valid |
| irq_out | output | 1 | External interrupt line |

## Verification
The priority search is tested in four situations: a single pending identity, several pending identities with only some of them enabled, identities spread across two words, and pending identities whose enable is cleared later. These cases separate a lowest-first search from one that is highest-first or that ignores the enable flags. The threshold is set to values just at, just above and just below the winner, to zero, to exactly `NUM_IDS` and to a masked value beyond it. This exposes off-by-one errors and bad comparisons. MMIO posts of zero, of `NUM_IDS`, to offset 4, to a misaligned address and outside the page all have to leave the pending words untouched. Partial-mask read-modify-writes show whether unmasked flags are preserved.

// File: rtl/mif_pkg.sv
// Shared constants, select codes and packing helper for the MSI interrupt file.
// Assumes 32-bit register words and an 11-bit identity field.
package mif_pkg;
    localparam int WORD_W  = 32;
    localparam int FIELD_W = 11;
    localparam int ID_LSB  = 16;
    localparam int SEL_W   = 8;
    localparam int IDX_W   = 6;

    localparam logic [SEL_W-1:0] SEL_DELIV  = 8'h00;
    localparam logic [SEL_W-1:0] SEL_THRESH = 8'h01;
    localparam logic [SEL_W-1:0] SEL_CLAIM  = 8'h02;
    localparam logic [1:0]       GRP_PEND   = 2'b01;
    localparam logic [1:0]       GRP_EN     = 2'b10;

    typedef enum logic [2:0] {
        K_NONE,
        K_DELIV,
        K_THRESH,
        K_CLAIM,
        K_PEND,
        K_EN
    } reg_kind_e;

    // Places an identity in both the identity and the priority field.
    function automatic logic [WORD_W-1:0] pack_top(input logic [FIELD_W-1:0] id);
        logic [WORD_W-1:0] v;
        v = '0;
        v[ID_LSB +: FIELD_W] = id;
        v[FIELD_W-1:0]       = id;
        return v;
    endfunction
endpackage

// File: rtl/mif_msi_decode.sv
// MMIO write decoder: converts a posted 32-bit message into a one-hot set vector.
// Assumes one page of 2**PAGE_SHIFT bytes; only page offset 0 (little-endian slot) is live.
module mif_msi_decode #(
    parameter int NUM_IDS    = 64,
    parameter int ADDR_W     = 16,
    parameter int PAGE_SHIFT = 12
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [NUM_IDS-1:0] set_vec
);
    logic aligned;
    logic in_page;
    logic at_slot0;
    logic id_ok;
    logic hit;

    // Qualify the access: alignment, page range, slot and identity range.
    always_comb begin
        aligned  = (addr[1:0] == 2'b00);
        in_page  = (addr[ADDR_W-1:PAGE_SHIFT] == '0);
        at_slot0 = (addr[PAGE_SHIFT-1:0] == '0);
        id_ok    = (wdata != 32'd0) && (wdata < 32'(NUM_IDS));
        hit      = wr_en && aligned && in_page && at_slot0 && id_ok;
    end

    // One flag per identity, set only for the identity carried by the message.
    for (genvar i = 0; i < NUM_IDS; i++) begin : g_set
        assign set_vec[i] = hit && (wdata == 32'(i));
    end
endmodule

// File: rtl/mif_top_select.sv
// Threshold-gated priority search: the lowest identity with pending and enable set wins.
// Assumes identity 0 never qualifies; result is 0 when nothing is eligible.
module mif_top_select
    import mif_pkg::*;
#(
    parameter int NUM_IDS = 64
) (
    input  logic [NUM_IDS-1:0] pend,
    input  logic [NUM_IDS-1:0] en,
    input  logic [FIELD_W-1:0] thresh,
    output logic [FIELD_W-1:0] top_id
);
    logic [NUM_IDS-1:0] ready;
    int                 limit;

    // Work out the exclusive upper bound set by the threshold.
    always_comb begin
        if (thresh != '0 && int'(thresh) <= NUM_IDS) limit = int'(thresh);
        else                                          limit = NUM_IDS;
    end

    // Scan from the top down so the lowest eligible identity is the last to be written.
    always_comb begin
        ready  = pend & en;
        top_id = '0;
        for (int i = NUM_IDS - 1; i >= 1; i--) begin
            if (ready[i] && i < limit) top_id = FIELD_W'(i);
        end
    end
endmodule

// File: rtl/mif_reg_bank.sv
// Register bank: holds pending/enable flags, delivery and threshold, and serves
// the read-modify-write port. Reads return the value before the access.
// Assumes select encoding from mif_pkg; one access per cycle; MSI sets win ties.
module mif_reg_bank
    import mif_pkg::*;
#(
    parameter int NUM_IDS = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_req,
    input  logic [SEL_W-1:0]     reg_sel,
    input  logic [WORD_W-1:0]    reg_wdata,
    input  logic [WORD_W-1:0]    reg_wmask,
    input  logic [NUM_IDS-1:0]   msi_set,
    input  logic [FIELD_W-1:0]   top_id,
    input  logic [WORD_W-1:0]    top_val,
    output logic [NUM_IDS-1:0]   pend_q,
    output logic [NUM_IDS-1:0]   en_q,
    output logic                 deliv_q,
    output logic [FIELD_W-1:0]   thr_q,
    output logic [WORD_W-1:0]    reg_rdata,
    output logic                 reg_rvalid
);
    localparam int NUM_WORDS = NUM_IDS / WORD_W;

    reg_kind_e          kind;
    logic [IDX_W-1:0]   widx;
    logic               is_wr;
    logic [NUM_IDS-1:0] mask_rep;
    logic [NUM_IDS-1:0] data_rep;
    logic [NUM_IDS-1:0] word_rep;
    logic [NUM_IDS-1:0] pend_d;
    logic [NUM_IDS-1:0] en_d;
    logic [WORD_W-1:0]  rdata_d;

    // Classify the select code into a register kind and a word index.
    always_comb begin
        widx  = reg_sel[IDX_W-1:0];
        is_wr = (reg_wmask != '0);
        kind  = K_NONE;
        if (reg_sel == SEL_DELIV)       kind = K_DELIV;
        else if (reg_sel == SEL_THRESH) kind = K_THRESH;
        else if (reg_sel == SEL_CLAIM)  kind = K_CLAIM;
        else if (reg_sel[SEL_W-1:IDX_W] == GRP_PEND && int'(widx) < NUM_WORDS) kind = K_PEND;
        else if (reg_sel[SEL_W-1:IDX_W] == GRP_EN   && int'(widx) < NUM_WORDS) kind = K_EN;
    end

    // Spread mask, data and word selection across the full flag vector.
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        assign mask_rep[w*WORD_W +: WORD_W] = reg_wmask;
        assign data_rep[w*WORD_W +: WORD_W] = reg_wdata;
        assign word_rep[w*WORD_W +: WORD_W] = {WORD_W{widx == IDX_W'(w)}};
    end

    // Next flag state: masked word write, claim clear, then MSI set; identity 0 held low.
    always_comb begin
        pend_d = pend_q;
        en_d   = en_q;
        if (reg_req && kind == K_PEND)
            pend_d = (pend_q & ~(mask_rep & word_rep)) | (data_rep & mask_rep & word_rep);
        if (reg_req && kind == K_EN)
            en_d = (en_q & ~(mask_rep & word_rep)) | (data_rep & mask_rep & word_rep);
        if (reg_req && kind == K_CLAIM && is_wr && top_id != '0) begin
            for (int i = 1; i < NUM_IDS; i++) begin
                if (int'(top_id) == i) pend_d[i] = 1'b0;
            end
        end
        pend_d    = pend_d | msi_set;
        pend_d[0] = 1'b0;
        en_d[0]   = 1'b0;
    end

    // Read multiplexer over the pre-access state.
    always_comb begin
        rdata_d = '0;
        case (kind)
            K_DELIV:  rdata_d = {{(WORD_W-1){1'b0}}, deliv_q};
            K_THRESH: rdata_d = {{(WORD_W-FIELD_W){1'b0}}, thr_q};
            K_CLAIM:  rdata_d = top_val;
            K_PEND: begin
                for (int w = 0; w < NUM_WORDS; w++)
                    if (int'(widx) == w) rdata_d = pend_q[w*WORD_W +: WORD_W];
            end
            K_EN: begin
                for (int w = 0; w < NUM_WORDS; w++)
                    if (int'(widx) == w) rdata_d = en_q[w*WORD_W +: WORD_W];
            end
            default:  rdata_d = '0;
        endcase
    end

    // State and response registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= '0;
            en_q       <= '0;
            deliv_q    <= 1'b0;
            thr_q      <= '0;
            reg_rdata  <= '0;
            reg_rvalid <= 1'b0;
        end else begin
            pend_q     <= pend_d;
            en_q       <= en_d;
            reg_rvalid <= reg_req;
            if (reg_req) reg_rdata <= rdata_d;
            if (reg_req && kind == K_DELIV && reg_wmask[0])
                deliv_q <= reg_wdata[0];
            if (reg_req && kind == K_THRESH)
                thr_q <= (thr_q & ~reg_wmask[FIELD_W-1:0]) | (reg_wdata[FIELD_W-1:0] & reg_wmask[FIELD_W-1:0]);
        end
    end
endmodule

// File: rtl/mif_msi_file.sv
// Top of the MSI interrupt file: decoder, register bank and priority search.
// Assumes NUM_IDS is a power of two between 64 and 2048 (highest identity 2**k-1).
module mif_msi_file
    import mif_pkg::*;
#(
    parameter int NUM_IDS    = 64,
    parameter int ADDR_W     = 16,
    parameter int PAGE_SHIFT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mmio_wr_en,
    input  logic [ADDR_W-1:0] mmio_addr,
    input  logic [31:0]       mmio_wdata,
    output logic [31:0]       mmio_rdata,
    input  logic              reg_req,
    input  logic [7:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    input  logic [31:0]       reg_wmask,
    output logic [31:0]       reg_rdata,
    output logic              reg_rvalid,
    output logic              irq_out
);
    if (NUM_IDS < 64 || NUM_IDS > (1 << FIELD_W) || (NUM_IDS & (NUM_IDS - 1)) != 0) begin : g_bad_ids
        $error("NUM_IDS must be a power of two from 64 to 2048");
    end

    logic [NUM_IDS-1:0] msi_set;
    logic [NUM_IDS-1:0] pend_q;
    logic [NUM_IDS-1:0] en_q;
    logic               deliv_q;
    logic [FIELD_W-1:0] thr_q;
    logic [FIELD_W-1:0] top_id;
    logic [WORD_W-1:0]  top_val;

    mif_msi_decode #(
        .NUM_IDS(NUM_IDS), .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)
    ) u_decode (
        .wr_en(mmio_wr_en), .addr(mmio_addr), .wdata(mmio_wdata), .set_vec(msi_set)
    );

    mif_top_select #(.NUM_IDS(NUM_IDS)) u_select (
        .pend(pend_q), .en(en_q), .thresh(thr_q), .top_id(top_id)
    );

    mif_reg_bank #(.NUM_IDS(NUM_IDS)) u_bank (
        .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_wmask(reg_wmask), .msi_set(msi_set),
        .top_id(top_id), .top_val(top_val), .pend_q(pend_q), .en_q(en_q),
        .deliv_q(deliv_q), .thr_q(thr_q), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid)
    );

    // Pack the winner into the claim-register format and drive the line.
    always_comb begin
        top_val    = pack_top(top_id);
        irq_out    = deliv_q && (top_id != '0);
        mmio_rdata = '0;
    end
endmodule

// File: rtl/mif_msi_file_chk.sv
// Property checker for the MSI interrupt file, attached by bind.
module mif_msi_file_chk
    import mif_pkg::*;
#(
    parameter int NUM_IDS = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_req,
    input logic [7:0]         reg_sel,
    input logic [31:0]        reg_wmask,
    input logic [31:0]        reg_rdata,
    input logic               reg_rvalid,
    input logic               mmio_wr_en,
    input logic [31:0]        mmio_wdata,
    input logic               irq_out,
    input logic [31:0]        top_val,
    input logic [FIELD_W-1:0] top_id,
    input logic [FIELD_W-1:0] thr_q,
    input logic [NUM_IDS-1:0] pend_q,
    input logic [NUM_IDS-1:0] en_q,
    input logic [NUM_IDS-1:0] msi_set
);
    logic below_hit;

    // Any ready identity strictly below the reported winner.
    always_comb begin
        below_hit = 1'b0;
        for (int i = 1; i < NUM_IDS; i++)
            if (i < int'(top_id) && pend_q[i] && en_q[i]) below_hit = 1'b1;
    end

    a_r1_bit0_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_req && (reg_sel == 8'h40 || reg_sel == 8'h80)) |-> !reg_rdata[0]);

    a_r2_fields: assert property (@(posedge clk) disable iff (!rst_n)
        top_val[26:16] == top_val[10:0] && top_val[31:27] == '0 && top_val[15:11] == '0);

    a_r2_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        top_id != '0 |-> !below_hit);

    a_r3_threshold: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_q != '0 && int'(thr_q) <= NUM_IDS && top_id != '0) |-> top_id < thr_q);

    a_r5_rise_after_access: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> $past(reg_req || mmio_wr_en));

    a_r6_claim_moves_on: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_sel == SEL_CLAIM && reg_wmask != '0 && top_id != '0 && msi_set == '0)
        |=> top_id != $past(top_id));

    a_r7_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        (mmio_wr_en && mmio_wdata == 32'd0) |-> msi_set == '0);

    a_r10_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req |=> reg_rvalid);

    a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_req |=> !reg_rvalid);
endmodule

bind mif_msi_file mif_msi_file_chk #(.NUM_IDS(NUM_IDS)) u_chk (.*);

// File: tb/mif_msi_file_test.sv
// Scoreboard bench: driver tasks keep a behavioural model, push expected read data,
// and a monitor pops and compares as responses appear.
module mif_msi_file_test;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mmio_wr_en = 1'b0;
    logic [15:0] mmio_addr = '0;
    logic [31:0] mmio_wdata = '0;
    logic [31:0] mmio_rdata;
    logic        reg_req = 1'b0;
    logic [7:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_wmask = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic        irq_out;

    int total = 0;
    int bad   = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    bit [N-1:0] m_pend = '0;
    bit [N-1:0] m_en   = '0;
    bit         m_deliv = 1'b0;
    bit [10:0]  m_thr  = '0;

    mif_msi_file #(.NUM_IDS(N)) uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int m_top();
        int lim;
        lim = (m_thr != 0 && int'(m_thr) <= N) ? int'(m_thr) : N;
        for (int i = 1; i < lim; i++) if (m_pend[i] && m_en[i]) return i;
        return 0;
    endfunction

    function automatic logic [31:0] m_topval();
        int t;
        t = m_top();
        return (32'(t) << 16) | 32'(t);
    endfunction

    // Monitor: compare each response against the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && reg_rvalid) begin
            if (exp_q.size() == 0) check("R10 unexpected response", reg_rdata, 32'hxxxx_xxxx);
            else check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
        end
    end

    // Driver: one register access, with model update and line check.
    task automatic reg_op(input logic [7:0] sel, input logic [31:0] wd, input logic [31:0] wm,
                          input string tag);
        logic [31:0] exp;
        int          w;
        @(negedge clk);
        reg_req = 1'b1; reg_sel = sel; reg_wdata = wd; reg_wmask = wm;
        exp = 32'd0;
        if (sel == 8'h00) begin
            exp = {31'd0, m_deliv};
            if (wm[0]) m_deliv = wd[0];
        end else if (sel == 8'h01) begin
            exp = {21'd0, m_thr};
            m_thr = (m_thr & ~wm[10:0]) | (wd[10:0] & wm[10:0]);
        end else if (sel == 8'h02) begin
            exp = m_topval();
            if (wm != 0 && m_top() != 0) m_pend[m_top()] = 1'b0;
        end else if (sel >= 8'h40 && sel < 8'h40 + N/32) begin
            w = int'(sel) - 'h40;
            exp = m_pend[w*32 +: 32];
            for (int b = 0; b < 32; b++) if (wm[b]) m_pend[w*32+b] = wd[b];
            m_pend[0] = 1'b0;
        end else if (sel >= 8'h80 && sel < 8'h80 + N/32) begin
            w = int'(sel) - 'h80;
            exp = m_en[w*32 +: 32];
            for (int b = 0; b < 32; b++) if (wm[b]) m_en[w*32+b] = wd[b];
            m_en[0] = 1'b0;
        end
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        reg_req = 1'b0; reg_wmask = '0;
        check("R5 irq after access", {31'd0, irq_out}, {31'd0, m_deliv && m_top() != 0});
    endtask

    // Driver: one MMIO post, with model update.
    task automatic msi(input logic [15:0] addr, input logic [31:0] data);
        @(negedge clk);
        mmio_wr_en = 1'b1; mmio_addr = addr; mmio_wdata = data;
        if (addr == 16'h0000 && data != 0 && data < N) m_pend[data] = 1'b1;
        @(negedge clk);
        mmio_wr_en = 1'b0;
        check("R5 irq after msi", {31'd0, irq_out}, {31'd0, m_deliv && m_top() != 0});
        check("R8 mmio reads zero", mmio_rdata, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R5 reset irq", {31'd0, irq_out}, 32'd0);
        check("R10 reset rvalid", {31'd0, reg_rvalid}, 32'd0);
        reg_op(8'h00, 0, 0, "R4 reset delivery");
        reg_op(8'h01, 0, 0, "R4 reset threshold");
        reg_op(8'h02, 0, 0, "R2 reset top");
        // R1: enable everything, bit 0 must stay zero
        reg_op(8'h80, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R9 enable word0 old");
        reg_op(8'h80, 0, 0, "R1 enable bit0 reads zero");
        // R2/R5: one pending, delivery off
        msi(16'h0000, 5);
        reg_op(8'h02, 0, 0, "R2 single winner 5");
        // R4: only bit 0 of delivery
        reg_op(8'h00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4 delivery old");
        reg_op(8'h00, 0, 0, "R4 delivery bit0 only");
        // R2: lower identity wins; word1 identity not enabled
        msi(16'h0000, 3);
        msi(16'h0000, 40);
        reg_op(8'h02, 0, 0, "R2 lowest of 3 5 40");
        // R3: threshold boundaries
        reg_op(8'h01, 3, 32'hFFFF_FFFF, "R3 thr write");
        reg_op(8'h02, 0, 0, "R3 thr 3 excludes 3");
        reg_op(8'h01, 4, 32'hFFFF_FFFF, "R3 thr write 4");
        reg_op(8'h02, 0, 0, "R3 thr 4 admits 3");
        reg_op(8'h01, 64, 32'hFFFF_FFFF, "R3 thr write N");
        reg_op(8'h02, 0, 0, "R3 thr N all eligible");
        reg_op(8'h01, 32'h0001_2345, 32'hFFFF_FFFF, "R4 thr write wide");
        reg_op(8'h01, 0, 0, "R4 thr masked to 11 bits");
        reg_op(8'h02, 0, 0, "R3 thr above N all eligible");
        reg_op(8'h01, 0, 32'hFFFF_FFFF, "R3 thr clear");
        // R6: claim clears the winner
        reg_op(8'h02, 32'hDEAD_BEEF, 32'h0000_0001, "R6 claim returns 3");
        reg_op(8'h02, 0, 0, "R6 next winner 5");
        // R7/R8: ignored posts
        msi(16'h0004, 7);
        msi(16'h0000, 0);
        msi(16'h0000, 64);
        msi(16'h0002, 9);
        msi(16'h1000, 11);
        msi(16'h0010, 12);
        reg_op(8'h40, 0, 0, "R7 R8 pending word0 unchanged");
        // R9: partial masked RMW, bit 0 ignored
        reg_op(8'h40, 32'h0000_0101, 32'h0000_0321, "R9 pend rmw old");
        reg_op(8'h40, 0, 0, "R9 pend rmw result");
        // R9: word1 enable, R2 lowest still wins
        reg_op(8'h81, 32'h0000_0100, 32'h0000_0100, "R9 en word1 old");
        reg_op(8'h02, 0, 0, "R2 lowest across words");
        reg_op(8'h41, 0, 0, "R9 pending word1");
        // R2: disable low ones so word1 identity wins
        reg_op(8'h80, 32'h0, 32'h0000_0FFE, "R9 en word0 clear low");
        reg_op(8'h02, 0, 0, "R2 word1 winner 40");
        // R10: unknown selects read zero and change nothing
        reg_op(8'hFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R10 unknown select");
        reg_op(8'h42, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R10 word past end");
        reg_op(8'h41, 0, 0, "R10 word1 untouched");
        // R5: delivery off drops the line with a winner present
        reg_op(8'h00, 0, 32'h1, "R5 delivery off");
        reg_op(8'h02, 0, 0, "R5 winner still present");
        repeat (2) @(negedge clk);
        check("R10 all responses seen", 32'(exp_q.size()), 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule